// File: doc/BRIEF.md
# Redundant-Thread Load Pin Table

This block keeps cache blocks stable while two copies of a program run one behind the other. Each load issued by the leading copy records its cache block address in a small associative table. If the block is already tracked, its count of outstanding loads goes up by one. The matching load of the trailing copy brings the count back down. While a block has a nonzero count it is pinned. The cache controller asks the table before it replaces or invalidates a block, and it receives a refusal for any pinned block. This ensures that the trailing copy reads the same data that the leading copy read.

An invalidation that hits a pinned block is not performed. Instead, the table marks the entry as having a pending invalidation. When the trailing copy's last outstanding load to that block completes, the table frees the entry and sends the block address back as a one-cycle release pulse, so the cache can carry out the invalidation at that point.

If the table has no free entry for a new block, or if a tracked block's count is already at its ceiling, the leading load is stalled. When the table stays full of pinned entries and no trailing load releases any of them for a programmable number of cycles, the table raises a deadlock flag so that recovery logic can step in. The entry count is a parameter, and the design supports 16 and 64 entries.

Top module: `load_pin_table`

## Requirements
- R1: After reset, the table is empty: `tbl_full`, `dl_flag` and `inv_rel_vld` are low, a leading load is not stalled, and every query is granted.
- R2: A leading load to an untracked block allocates an entry with count 1. A leading load to a tracked block adds one to that entry's count. Each block address occupies at most one entry.
- R3: A trailing load to a tracked block subtracts one from its count. A trailing load to an untracked block has no effect.
- R4: `evq_grant` is high exactly when `evq_vld` is high and the queried block is not tracked. Tracked blocks always have a nonzero count, so they are refused.
- R5: A query with `evq_inval`=1 that hits a tracked block sets that entry's pending-invalidate mark. A query with `evq_inval`=0 (replacement) leaves the mark unchanged.
- R6: When a count reaches zero with the pending mark set, the entry is freed. In the following cycle only, `inv_rel_vld` is high and `inv_rel_blk` carries the block address.
- R7: When a count reaches zero without the pending mark, the entry is freed and no release pulse is produced.
- R8: `tbl_full` is high when every entry is in use. A leading load to an untracked block while the table is full is stalled (`ld_lead_stall` high in the same cycle) and allocates nothing.
- R9: A leading load to a tracked block whose count equals 2^CNT_W-1 is stalled and leaves the count unchanged.
- R10: A leading load and a trailing load to the same tracked block in the same cycle leave its count unchanged.
- R11: The watch counter counts consecutive clock edges on which the table was full of pinned entries and no trailing load hit. Any other edge resets the counter to zero. `dl_flag` is high while that count is nonzero and at least `dl_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_lead_vld | input | 1 | Leading-copy load present |
| ld_lead_blk | input | BLK_W | Cache block address of the leading load |
| ld_lead_stall | output | 1 | Leading load refused this cycle |
| ld_trail_vld | input | 1 | Trailing-copy load present |
| ld_trail_blk | input | BLK_W | Cache block address of the trailing load |
| evq_vld | input | 1 | Cache replace/invalidate query present |
| evq_inval | input | 1 | 1 = invalidation query, 0 = replacement query |
| evq_blk | input | BLK_W | Block address being queried |
| evq_grant | output | 1 | Query may proceed |
| inv_rel_vld | output | 1 | Deferred invalidation released (one cycle) |
| inv_rel_blk | output | BLK_W | Block address of the released invalidation |
| tbl_full | output | 1 | All entries in use |
| dl_limit | input | DL_W | Deadlock detection threshold in cycles |
| dl_flag | output | 1 | Deadlock detected |

## Verification
The hardest condition to reach is a deadlock. The table must fill with pinned blocks and then stay without any trailing hit for `dl_limit` cycles. The random sweep only reaches it by chance, because trailing loads keep draining entries. The bench therefore fills all four entries of a small configuration with distinct blocks and then holds the trailing port idle or aims it at untracked blocks. It checks the edge on which the flag rises, and checks that a single trailing hit clears it. The random sweep also includes trailing-silent windows, which reach the full-table and deadlock states repeatedly under both thresholds.

// File: rtl/alab_pkg.sv
package alab_pkg;

  // Outstanding-load count after an optional increment and decrement.
  function automatic int unsigned count_step(int unsigned c, logic up, logic dn);
    int unsigned r;
    r = c;
    if (up) r = r + 1;
    if (dn) r = r - 1;
    return r;
  endfunction

  // Saturating increment used by the stall watch counter.
  function automatic int unsigned sat_next(int unsigned c, int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

  // Deadlock decision from the watch count and the programmed limit.
  function automatic logic dl_trip(int unsigned cyc, int unsigned lim);
    return (cyc != 0) && (cyc >= lim);
  endfunction

endpackage

// File: rtl/alab_entry.sv
module alab_entry #(
  parameter int BLK_W = 26,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             pend_set_i,
  output logic             valid_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rel_o
);
  import alab_pkg::*;

  logic             valid_q;
  logic [BLK_W-1:0] blk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             pend_nx;
  logic             drain;

  always_comb begin
    cnt_nx  = CNT_W'(count_step(32'(cnt_q), inc_i, dec_i));
    pend_nx = pend_q | pend_set_i;
    drain   = valid_q && (cnt_nx == '0);
  end

  assign rel_o   = drain && pend_nx;
  assign valid_o = valid_q;
  assign blk_o   = blk_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else if (!valid_q) begin
      if (alloc_i) begin
        valid_q <= 1'b1;
        blk_q   <= blk_i;
        cnt_q   <= CNT_W'(1);
        pend_q  <= 1'b0;
      end
    end else if (drain) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      pend_q <= pend_nx;
    end
  end

endmodule

// File: rtl/alab_match.sv
module alab_match #(
  parameter int N_ENT = 16,
  parameter int BLK_W = 26
) (
  input  logic                        en_i,
  input  logic [BLK_W-1:0]            key_i,
  input  logic [N_ENT-1:0]            valid_i,
  input  logic [N_ENT-1:0][BLK_W-1:0] blk_i,
  output logic [N_ENT-1:0]            hit_vec_o,
  output logic                        hit_o
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec_o[i] = en_i && valid_i[i] && (blk_i[i] == key_i);
  end

  assign hit_o = |hit_vec_o;

endmodule

// File: rtl/alab_free_pick.sv
module alab_free_pick #(
  parameter int N_ENT = 16
) (
  input  logic [N_ENT-1:0] valid_i,
  output logic [N_ENT-1:0] pick_o,
  output logic             any_free_o,
  output logic             full_o
);
  logic [N_ENT-1:0] seen;

  // Lowest free entry wins: a ripple of "a free slot was already seen".
  for (genvar i = 0; i < N_ENT; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign seen[i]   = !valid_i[i];
      assign pick_o[i] = !valid_i[i];
    end else begin : g_rest
      assign seen[i]   = seen[i-1] || !valid_i[i];
      assign pick_o[i] = !valid_i[i] && !seen[i-1];
    end
  end

  assign any_free_o = seen[N_ENT-1];
  assign full_o     = &valid_i;

endmodule

// File: rtl/alab_dl_watch.sv
module alab_dl_watch #(
  parameter int DL_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_i,
  input  logic [DL_W-1:0] limit_i,
  output logic            flag_o
);
  import alab_pkg::*;

  localparam int unsigned CYC_MAX = (1 << DL_W) - 1;

  logic [DL_W-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cyc_q <= '0;
    else if (arm_i) cyc_q <= DL_W'(sat_next(32'(cyc_q), CYC_MAX));
    else            cyc_q <= '0;
  end

  assign flag_o = dl_trip(32'(cyc_q), 32'(limit_i));

endmodule

// File: rtl/load_pin_table.sv
module load_pin_table #(
  parameter int N_ENT = 16,
  parameter int BLK_W = 26,
  parameter int CNT_W = 6,
  parameter int DL_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_lead_vld,
  input  logic [BLK_W-1:0] ld_lead_blk,
  output logic             ld_lead_stall,
  input  logic             ld_trail_vld,
  input  logic [BLK_W-1:0] ld_trail_blk,
  input  logic             evq_vld,
  input  logic             evq_inval,
  input  logic [BLK_W-1:0] evq_blk,
  output logic             evq_grant,
  output logic             inv_rel_vld,
  output logic [BLK_W-1:0] inv_rel_blk,
  output logic             tbl_full,
  input  logic [DL_W-1:0]  dl_limit,
  output logic             dl_flag
);
  localparam logic [CNT_W-1:0] CNT_CEIL = {CNT_W{1'b1}};

  logic [N_ENT-1:0]            valid_vec;
  logic [N_ENT-1:0][BLK_W-1:0] blk_arr;
  logic [N_ENT-1:0][CNT_W-1:0] cnt_arr;
  logic [N_ENT-1:0]            rel_vec;
  logic [N_ENT-1:0]            ceil_vec;
  logic [N_ENT-1:0]            busy_vec;

  logic [N_ENT-1:0] l_vec, t_vec, q_vec, pick_vec;
  logic             l_hit, t_hit, q_hit, any_free, full_w;
  logic             lead_ceil, lead_go, dl_arm;
  logic             rel_any;
  logic [BLK_W-1:0] rel_blk_sel;
  logic             rel_vld_q;
  logic [BLK_W-1:0] rel_blk_q;

  alab_match #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_lead_cam (
    .en_i(ld_lead_vld), .key_i(ld_lead_blk), .valid_i(valid_vec),
    .blk_i(blk_arr), .hit_vec_o(l_vec), .hit_o(l_hit));

  alab_match #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_trail_cam (
    .en_i(ld_trail_vld), .key_i(ld_trail_blk), .valid_i(valid_vec),
    .blk_i(blk_arr), .hit_vec_o(t_vec), .hit_o(t_hit));

  alab_match #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_query_cam (
    .en_i(evq_vld), .key_i(evq_blk), .valid_i(valid_vec),
    .blk_i(blk_arr), .hit_vec_o(q_vec), .hit_o(q_hit));

  alab_free_pick #(.N_ENT(N_ENT)) u_pick (
    .valid_i(valid_vec), .pick_o(pick_vec),
    .any_free_o(any_free), .full_o(full_w));

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign ceil_vec[i] = (cnt_arr[i] == CNT_CEIL);
    assign busy_vec[i] = valid_vec[i] && (cnt_arr[i] != '0);

    alab_entry #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (lead_go && !l_hit && pick_vec[i]),
      .blk_i      (ld_lead_blk),
      .inc_i      (lead_go && l_vec[i]),
      .dec_i      (t_vec[i]),
      .pend_set_i (evq_inval && q_vec[i]),
      .valid_o    (valid_vec[i]),
      .blk_o      (blk_arr[i]),
      .cnt_o      (cnt_arr[i]),
      .rel_o      (rel_vec[i])
    );
  end

  // Leading load is refused on a full table (new block) or a counter at its ceiling.
  assign lead_ceil     = |(l_vec & ceil_vec);
  assign ld_lead_stall = ld_lead_vld && (l_hit ? lead_ceil : !any_free);
  assign lead_go       = ld_lead_vld && !ld_lead_stall;

  assign evq_grant = evq_vld && !q_hit;
  assign tbl_full  = full_w;

  // At most one trailing decrement per cycle, so at most one entry drains.
  always_comb begin
    rel_blk_sel = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (rel_vec[i]) rel_blk_sel = rel_blk_sel | blk_arr[i];
    end
  end
  assign rel_any = |rel_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_vld_q <= 1'b0;
      rel_blk_q <= '0;
    end else begin
      rel_vld_q <= rel_any;
      rel_blk_q <= rel_any ? rel_blk_sel : rel_blk_q;
    end
  end

  assign inv_rel_vld = rel_vld_q;
  assign inv_rel_blk = rel_blk_q;

  assign dl_arm = full_w && (&busy_vec) && !t_hit;

  alab_dl_watch #(.DL_W(DL_W)) u_dl (
    .clk(clk), .rst_n(rst_n), .arm_i(dl_arm),
    .limit_i(dl_limit), .flag_o(dl_flag));

endmodule

// File: rtl/load_pin_table_chk.sv
module load_pin_table_chk #(
  parameter int N_ENT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lead_vld,
  input logic             lead_stall,
  input logic             lead_hit,
  input logic [N_ENT-1:0] lead_vec,
  input logic             full,
  input logic             trail_vld,
  input logic             rel_vld,
  input logic             dl_flag,
  input logic             evq_vld,
  input logic             evq_grant
);

  // R1
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_vld |-> !lead_stall);

  // R8
  miss_stall_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_vld && !lead_hit && !full) |-> !lead_stall);

  // R2
  unique_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lead_vec));

  // R6
  release_after_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld |-> $past(trail_vld));

  // R11
  deadlock_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_flag |-> full);

  // R4
  grant_needs_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evq_grant |-> evq_vld);

endmodule

bind load_pin_table load_pin_table_chk #(.N_ENT(N_ENT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lead_vld   (ld_lead_vld),
  .lead_stall (ld_lead_stall),
  .lead_hit   (l_hit),
  .lead_vec   (l_vec),
  .full       (tbl_full),
  .trail_vld  (ld_trail_vld),
  .rel_vld    (inv_rel_vld),
  .dl_flag    (dl_flag),
  .evq_vld    (evq_vld),
  .evq_grant  (evq_grant)
);

// File: tb/tb_load_pin_table.sv
module tb_load_pin_table;
  localparam int N  = 4;
  localparam int BW = 6;
  localparam int CW = 2;
  localparam int DW = 6;
  localparam int CMAX = (1 << CW) - 1;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lv = 1'b0, tv = 1'b0, qv = 1'b0, qi = 1'b0;
  logic [BW-1:0] lb = '0, tb = '0, qb = '0;
  logic [DW-1:0] lim = DW'(8);
  logic stall, grant, rel_v, full, dl;
  logic [BW-1:0] rel_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state
  int m_val[N], m_blk[N], m_cnt[N], m_pend[N];
  int m_rel_v = 0, m_rel_b = 0, m_dl = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  load_pin_table #(.N_ENT(N), .BLK_W(BW), .CNT_W(CW), .DL_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ld_lead_vld(lv), .ld_lead_blk(lb), .ld_lead_stall(stall),
    .ld_trail_vld(tv), .ld_trail_blk(tb),
    .evq_vld(qv), .evq_inval(qi), .evq_blk(qb), .evq_grant(grant),
    .inv_rel_vld(rel_v), .inv_rel_blk(rel_b),
    .tbl_full(full), .dl_limit(lim), .dl_flag(dl));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find(input bit en, input int b);
    int r = -1;
    for (int i = 0; i < N; i++) if (en && m_val[i] != 0 && m_blk[i] == b) r = i;
    return r;
  endfunction

  function automatic int nfree();
    int r = 0;
    for (int i = 0; i < N; i++) if (m_val[i] == 0) r++;
    return r;
  endfunction

  // One cycle: drive after negedge, compare before posedge, advance model at posedge.
  task automatic step(input bit l_v, input int l_b, input bit t_v, input int t_b,
                      input bit q_v, input bit q_i, input int q_b);
    int lh, th, qh, ff, e_stall, nc, np;
    @(negedge clk);
    lv = l_v; lb = BW'(l_b); tv = t_v; tb = BW'(t_b);
    qv = q_v; qi = q_i; qb = BW'(q_b);
    #1;
    lh = find(l_v, l_b); th = find(t_v, t_b); qh = find(q_v, q_b);
    ff = -1;
    for (int i = N - 1; i >= 0; i--) if (m_val[i] == 0) ff = i;
    e_stall = l_v && ((lh >= 0) ? (m_cnt[lh] == CMAX) : (nfree() == 0));
    chk((lh >= 0) ? "R9 stall" : "R8 stall", int'(stall), e_stall);
    chk("R4 grant", int'(grant), int'(q_v && qh < 0));
    chk("R8 full", int'(full), int'(nfree() == 0));
    chk("R6 release", int'(rel_v), m_rel_v);
    if (m_rel_v != 0) chk("R6 release block", int'(rel_b), m_rel_b);
    chk("R11 deadlock", int'(dl), int'(m_dl != 0 && m_dl >= int'(lim)));
    @(posedge clk);
    // watch counter
    if (nfree() == 0 && th < 0) m_dl = (m_dl >= DMAX) ? DMAX : m_dl + 1;
    else m_dl = 0;
    m_rel_v = 0;
    for (int i = 0; i < N; i++) begin
      if (m_val[i] != 0) begin
        nc = m_cnt[i] + ((l_v && !e_stall && lh == i) ? 1 : 0) - ((th == i) ? 1 : 0);
        np = m_pend[i] | ((q_v && q_i && qh == i) ? 1 : 0);
        if (nc == 0) begin
          m_val[i] = 0;
          if (np != 0) begin m_rel_v = 1; m_rel_b = m_blk[i]; end
          m_pend[i] = 0;
        end else begin
          m_cnt[i] = nc; m_pend[i] = np;
        end
      end
    end
    if (l_v && !e_stall && lh < 0) begin
      m_val[ff] = 1; m_blk[ff] = l_b; m_cnt[ff] = 1; m_pend[ff] = 0;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  // Replacement query has no side effect; returns the grant seen this cycle.
  task automatic probe(input int b, input int exp, input string req);
    @(negedge clk);
    lv = 0; tv = 0; qv = 1; qi = 0; qb = BW'(b);
    #1;
    chk(req, int'(grant), exp);
    @(posedge clk);
    m_rel_v = 0;
    if (nfree() == 0) m_dl = (m_dl >= DMAX) ? DMAX : m_dl + 1; else m_dl = 0;
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % m);
  endfunction

  task automatic sweep(input int steps, input int limit);
    bit quiet;
    lim = DW'(limit);
    for (int s = 0; s < steps; s++) begin
      quiet = ((s % 150) >= 120);
      step(rnd(10) < 6, rnd(6), !quiet && rnd(10) < 5, rnd(6),
           rnd(2) == 1, rnd(2) == 1, rnd(6));
    end
    for (int s = 0; s < 40; s++) step(0, 0, 1, s % 6, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_blk[i] = 0; m_cnt[i] = 0; m_pend[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 full", int'(full), 0);
    chk("R1 deadlock", int'(dl), 0);
    chk("R1 release", int'(rel_v), 0);
    probe(33, 1, "R1 grant");

    // R2 / R3: three leads then counted drain, untracked trail ignored
    repeat (3) step(1, 5, 0, 0, 0, 0, 0);
    probe(5, 0, "R2 pinned after leads");
    step(0, 0, 1, 9, 0, 0, 0);
    probe(5, 0, "R3 untracked trail ignored");
    repeat (2) step(0, 0, 1, 5, 0, 0, 0);
    probe(5, 0, "R3 still pinned at count 1");
    step(0, 0, 1, 5, 0, 0, 0);
    probe(5, 1, "R2 R3 freed after third trail");

    // R9 ceiling stall
    repeat (3) step(1, 7, 0, 0, 0, 0, 0);
    step(1, 7, 0, 0, 0, 0, 0);
    repeat (2) step(0, 0, 1, 7, 0, 0, 0);
    probe(7, 0, "R9 stalled lead did not count");
    step(0, 0, 1, 7, 0, 0, 0);
    probe(7, 1, "R9 drained");

    // R10 simultaneous inc/dec
    step(1, 8, 0, 0, 0, 0, 0);
    step(1, 8, 1, 8, 0, 0, 0);
    probe(8, 0, "R10 count held");
    step(0, 0, 1, 8, 0, 0, 0);
    probe(8, 1, "R10 single trail frees");

    // R7 / R5 replacement query does not mark pending
    step(1, 10, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 10);
    step(0, 0, 1, 10, 0, 0, 0);
    #1 chk("R7 no release pulse", int'(rel_v), 0);
    idle();
    // R5 / R6 invalidation deferred then released
    step(1, 10, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 10);
    step(0, 0, 1, 10, 0, 0, 0);
    #1 chk("R6 release pulse", int'(rel_v), 1);
    chk("R5 released block", int'(rel_b), 10);
    idle();
    #1 chk("R6 pulse is one cycle", int'(rel_v), 0);

    // R8 / R11 fill, stall, deadlock
    lim = DW'(8);
    for (int b = 1; b <= 4; b++) step(1, b, 0, 0, 0, 0, 0);
    #1 chk("R8 full after four blocks", int'(full), 1);
    step(1, 11, 1, 11, 0, 0, 0);
    repeat (5) idle();
    #1 chk("R11 not yet at limit", int'(dl), 0);
    repeat (3) idle();
    #1 chk("R11 flag at limit", int'(dl), 1);
    step(0, 0, 1, 1, 0, 0, 0);
    #1 chk("R11 cleared by trailing hit", int'(dl), 0);
    for (int b = 2; b <= 4; b++) step(0, 0, 1, b, 0, 0, 0);
    idle();

    sweep(3000, 8);
    sweep(3000, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule